// File: doc/BRIEF.md
# Eight-bit ALU with protected status flags

This block is the arithmetic and logic stage of an accumulator-style core. It holds the working register W internally and combines it with a second operand. That operand is either a byte read from the register file or an immediate literal, picked per operation. The operation arrives as a four-bit select code. The block returns the 8-bit result, a mask telling which flags the operation touched, and the updated W and STATUS registers. STATUS holds Carry, Digit Carry and Zero, two reset-status bits that instructions cannot change, and three general bits.

Operations enter on a valid/ready channel, and results leave on a second one. A transfer happens on any clock edge where both valid and ready are high. One result register sits between the channels. The input is ready when that register is empty, or when its result is being taken in the same cycle. While the consumer holds `out_ready` low, the result and the flag mask stay frozen and no new operation is accepted. W and STATUS change only on an accepted operation.

Subtraction computes operand minus W. On subtraction, Carry and Digit Carry act as inverted borrows. An operation can name STATUS as its destination. In that case, the flags the operation updates keep the ALU's values, not the written byte.

Top module: `alu8_flags`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_flags_upd` hold their values and no operation is accepted.
- R2: Add (code 0) returns operand + W modulo 256. C is the carry out of bit 7, DC is the carry from bit 3 into bit 4, and Z is set for a zero result.
- R3: Subtract (code 1) returns operand − W modulo 256. C is 1 when operand ≥ W, DC is 1 when the low nibble of the operand ≥ the low nibble of W, and Z is set for a zero result.
- R4: The following operations update only Z:
  - AND (2), OR (3) and XOR (4) with W.
  - Complement of the operand (5).
  - Increment (6) and decrement (7) of the operand, wrapping at 8 bits.
  - Move of the operand (11).
  - Clear to zero (12).
  - Codes 13 to 15, which act as a move.
- R5: Rotate left (8) shifts the operand left with the old C entering bit 0, and C takes the old bit 7. Rotate right (9) shifts the operand right with the old C entering bit 7, and C takes the old bit 0. Both update only C.
- R6: Swap (10) exchanges the operand's two nibbles and updates no flag.
- R7: `out_flags_upd` marks the flags the operation updated: bit 2 for Z, bit 1 for DC and bit 0 for C.
- R8: The operand is `in_lit` when `in_use_lit` is 1 and `in_file` when it is 0.
- R9: An accepted operation with `in_dst_w` high loads its result into W. Otherwise W is unchanged.
- R10: STATUS layout and write protection:
  - Bit 0 is C, bit 1 is DC and bit 2 is Z.
  - Bits 3 and 4 are the power-down and timeout bits. Both are 1 from reset and no operation changes them.
  - Bits 7..5 are general bits.
  - With `in_dst_status` high, bits 7..5 take the result. Flag bits the operation updates take the ALU flags. Flag bits it does not update take the matching result bits.
- R11: After reset W is 0x00, STATUS is 0x18 and `out_valid` is low.
- R12: In a cycle with no accepted operation, W and STATUS keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 4 | Operation select code |
| in_use_lit | input | 1 | 1 selects the literal operand, 0 the register-file byte |
| in_file | input | 8 | Register-file operand byte |
| in_lit | input | 8 | Immediate literal operand |
| in_dst_w | input | 1 | Write the result into W |
| in_dst_status | input | 1 | The result is destined for STATUS |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result byte |
| out_flags_upd | output | 3 | Flags updated by the operation: {Z, DC, C} |
| w_o | output | 8 | Current working register |
| status_o | output | 8 | Current STATUS register |

## Verification
The assertions check the following on every cycle:
- The result and the mask are frozen under back-pressure.
- The input is ready whenever the result register is empty.
- W and STATUS are unchanged when nothing is accepted.
- W is unchanged when it is not the destination.
- The general STATUS bits are unchanged when STATUS is not the destination.
- The reset-status bits never move.
- The logical and rotate operations report the right flag mask.
- The Zero flag agrees with the result.

Only the bench's scenarios show the values of the arithmetic: the carry and digit-carry edges such as 0x0F + 0x01 and 0x00 − 0x01, the rotation through C, and the way a write to STATUS merges the result with the protected flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_SWAP = 4'd10,
    OP_MOV  = 4'd11,
    OP_CLR  = 4'd12
  } alu_op_e;

  // Flag vector order, also the order of the update mask.
  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flags_t;

  localparam int FLAG_N  = 3;
  localparam int STS_PD  = 3;
  localparam int STS_TO  = 4;
  localparam int STS_GEN = 5;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hcout
);
  localparam int NIB = DW / 2;
  localparam int HIW = DW - NIB;

  logic [NIB:0] lo;
  logic [HIW:0] hi;

  // Split at the nibble boundary so the half carry is a real wire.
  always_comb begin
    lo = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    hi = {1'b0, a[DW-1:NIB]} + {1'b0, b[DW-1:NIB]} + {{HIW{1'b0}}, lo[NIB]};
  end

  assign sum   = {hi[HIW-1:0], lo[NIB-1:0]};
  assign cout  = hi[HIW];
  assign hcout = lo[NIB];
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] wreg,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output flags_t        flg,
  output flags_t        msk
);
  localparam int NIB = DW / 2;

  logic [DW-1:0] add_b;
  logic          add_ci;
  logic [DW-1:0] add_s;
  logic          add_co;
  logic          add_hc;

  // One adder serves add, subtract (opnd + ~W + 1), increment and decrement.
  always_comb begin
    add_b  = wreg;
    add_ci = 1'b0;
    case (op)
      OP_SUB: begin add_b = ~wreg;       add_ci = 1'b1; end
      OP_INC: begin add_b = '0;          add_ci = 1'b1; end
      OP_DEC: begin add_b = '1;          add_ci = 1'b0; end
      default: ;
    endcase
  end

  alu8_adder #(.DW(DW)) u_add (
    .a    (opnd),
    .b    (add_b),
    .cin  (add_ci),
    .sum  (add_s),
    .cout (add_co),
    .hcout(add_hc)
  );

  always_comb begin
    res    = opnd;
    flg    = '0;
    flg.c  = c_in;
    msk    = '0;
    msk.z  = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        res    = add_s;
        flg.c  = add_co;
        flg.dc = add_hc;
        msk    = '{z: 1'b1, dc: 1'b1, c: 1'b1};
      end
      OP_AND:  res = opnd & wreg;
      OP_OR:   res = opnd | wreg;
      OP_XOR:  res = opnd ^ wreg;
      OP_COM:  res = ~opnd;
      OP_INC,
      OP_DEC:  res = add_s;
      OP_RLC: begin
        res   = {opnd[DW-2:0], c_in};
        flg.c = opnd[DW-1];
        msk   = '{z: 1'b0, dc: 1'b0, c: 1'b1};
      end
      OP_RRC: begin
        res   = {c_in, opnd[DW-1:1]};
        flg.c = opnd[0];
        msk   = '{z: 1'b0, dc: 1'b0, c: 1'b1};
      end
      OP_SWAP: begin
        res = {opnd[NIB-1:0], opnd[DW-1:NIB]};
        msk = '0;
      end
      OP_CLR:  res = '0;
      default: res = opnd;
    endcase
    flg.z = (res == '0);
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic                 dst_sts,
  input  logic [FLAG_N-1:0]    res_flagpos,
  input  logic [DW-1:STS_GEN]  res_gen,
  input  logic [FLAG_N-1:0]    flg,
  input  logic [FLAG_N-1:0]    msk,
  output logic [DW-1:0]        status
);
  logic [FLAG_N-1:0]   flag_q;
  logic [1:0]          rstat_q;
  logic [DW-1:STS_GEN] gen_q;

  // Each flag bit: ALU value when the operation owns it, else the written
  // result bit when STATUS is the destination, else unchanged.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else if (upd && msk[i])
        flag_q[i] <= flg[i];
      else if (upd && dst_sts)
        flag_q[i] <= res_flagpos[i];
    end
  end

  // Timeout and power-down bits: set by reset, never written by operations.
  always_ff @(posedge clk) begin
    if (rst) rstat_q <= 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst)
      gen_q <= '0;
    else if (upd && dst_sts)
      gen_q <= res_gen;
  end

  assign status = {gen_q, rstat_q, flag_q};
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic          in_use_lit,
  input  logic [DW-1:0] in_file,
  input  logic [DW-1:0] in_lit,
  input  logic          in_dst_w,
  input  logic          in_dst_status,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [2:0]    out_flags_upd,
  output logic [DW-1:0] w_o,
  output logic [DW-1:0] status_o
);
  logic          accept;
  logic [DW-1:0] operand;
  logic [DW-1:0] w_q;
  logic [DW-1:0] dp_res;
  flags_t        dp_flg;
  flags_t        dp_msk;
  logic          res_v_q;
  logic [DW-1:0] res_q;
  logic [2:0]    msk_q;

  assign in_ready = !res_v_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign operand  = in_use_lit ? in_lit : in_file;

  alu8_datapath #(.DW(DW)) u_dp (
    .op   (alu_op_e'(in_op)),
    .opnd (operand),
    .wreg (w_q),
    .c_in (status_o[0]),
    .res  (dp_res),
    .flg  (dp_flg),
    .msk  (dp_msk)
  );

  alu8_status #(.DW(DW)) u_sts (
    .clk        (clk),
    .rst        (rst),
    .upd        (accept),
    .dst_sts    (in_dst_status),
    .res_flagpos(dp_res[FLAG_N-1:0]),
    .res_gen    (dp_res[DW-1:STS_GEN]),
    .flg        (dp_flg),
    .msk        (dp_msk),
    .status     (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      w_q <= '0;
    else if (accept && in_dst_w)
      w_q <= dp_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_v_q <= 1'b0;
      res_q   <= '0;
      msk_q   <= '0;
    end else if (accept) begin
      res_v_q <= 1'b1;
      res_q   <= dp_res;
      msk_q   <= dp_msk;
    end else if (out_ready) begin
      res_v_q <= 1'b0;
    end
  end

  assign out_valid     = res_v_q;
  assign out_result    = res_q;
  assign out_flags_upd = msk_q;
  assign w_o           = w_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_op,
  input logic          in_dst_w,
  input logic          in_dst_status,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic [2:0]    out_flags_upd,
  input logic [DW-1:0] w_o,
  input logic [DW-1:0] status_o
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags_upd));

  // R1
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R9
  w_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc && in_dst_w) |=> $stable(w_o));

  // R12
  idle_status_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(status_o) && $stable(w_o));

  // R10
  general_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc && in_dst_status) |=> $stable(status_o[DW-1:5]));

  // R10
  reset_bits_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(status_o[4:3]));

  // R4
  logic_mask_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (in_op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd11, 4'd12})
    |=> out_flags_upd == 3'b100);

  // R5
  rotate_mask_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (in_op inside {4'd8, 4'd9}) |=> out_flags_upd == 3'b001);

  // R7
  zero_matches_result_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !in_dst_status |=> (!out_flags_upd[2] || (status_o[2] == (out_result == '0))));
endmodule

bind alu8_flags alu8_flags_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_op        (in_op),
  .in_dst_w     (in_dst_w),
  .in_dst_status(in_dst_status),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_flags_upd(out_flags_upd),
  .w_o          (w_o),
  .status_o     (status_o)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic       in_use_lit = 1'b0;
  logic [7:0] in_file = '0;
  logic [7:0] in_lit = '0;
  logic       in_dst_w = 1'b0;
  logic       in_dst_status = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [2:0] out_flags_upd;
  logic [7:0] w_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu8_flags uut (.*);

  // ---------------- reference model ----------------
  logic [7:0] mw, ms, mres;
  logic [2:0] mmask;
  logic       mv;
  int         mop;

  task automatic model_op(input int op, input int a, input int w, input bit cin,
                          output int r, output bit c, output bit dc, output bit [2:0] mk);
    c = cin; dc = 1'b0; mk = 3'b100;
    case (op)
      0: begin r = (a + w) % 256; c = (a + w) > 255; dc = ((a % 16) + (w % 16)) > 15; mk = 3'b111; end
      1: begin r = (a - w + 256) % 256; c = a >= w; dc = (a % 16) >= (w % 16); mk = 3'b111; end
      2: r = a & w;
      3: r = a | w;
      4: r = a ^ w;
      5: r = 255 - a;
      6: r = (a + 1) % 256;
      7: r = (a + 255) % 256;
      8: begin r = ((a * 2) % 256) + (cin ? 1 : 0); c = a >= 128; mk = 3'b001; end
      9: begin r = (a / 2) + (cin ? 128 : 0); c = (a % 2) == 1; mk = 3'b001; end
      10: begin r = ((a % 16) * 16) + (a / 16); mk = 3'b000; end
      12: r = 0;
      default: r = a;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mw = 8'h00; ms = 8'h18; mv = 1'b0; mres = '0; mmask = '0; mop = 0;
    end else begin
      bit acc;
      acc = in_valid && (!mv || out_ready);
      if (acc) begin
        int a, r;
        bit c, dc;
        bit [2:0] mk;
        logic [7:0] rb, ns;
        a = in_use_lit ? in_lit : in_file;          // R8 operand selection
        model_op(in_op, a, mw, ms[0], r, c, dc, mk);
        rb = r[7:0];
        ns = ms;
        if (in_dst_status) ns[7:5] = rb[7:5];
        ns[0] = mk[0] ? c : (in_dst_status ? rb[0] : ms[0]);
        ns[1] = mk[1] ? dc : (in_dst_status ? rb[1] : ms[1]);
        ns[2] = mk[2] ? (rb == 8'h00) : (in_dst_status ? rb[2] : ms[2]);
        if (in_dst_w) mw = rb;
        ms = ns; mres = rb; mmask = mk; mv = 1'b1; mop = in_op;
      end else if (out_ready) begin
        mv = 1'b0;
      end
    end
  end

  function automatic string res_tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      8, 9: return "R5";
      10: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from both edges
  always begin
    @(posedge clk);
    #2;
    if (!rst && !done) begin
      check("R1 in_ready", {7'b0, in_ready}, {7'b0, (!mv || out_ready)});
      check("R1 out_valid", {7'b0, out_valid}, {7'b0, mv});
      if (mv) begin
        check({res_tag(mop), " result"}, out_result, mres);
        check("R7 flag mask", {5'b0, out_flags_upd}, {5'b0, mmask});
      end
      check("R9 W", w_o, mw);
      check("R10 STATUS", status_o, ms);
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic do_op(input int op, input bit uselit, input logic [7:0] f,
                       input logic [7:0] l, input bit dw, input bit ds);
    @(negedge clk);
    in_op = op[3:0]; in_use_lit = uselit; in_file = f; in_lit = l;
    in_dst_w = dw; in_dst_status = ds; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 W after reset", w_o, 8'h00);
    check("R11 STATUS after reset", status_o, 8'h18);
    check("R11 out_valid after reset", {7'b0, out_valid}, 8'h00);

    do_op(11, 1, 8'h00, 8'h01, 1, 0);           // W = 1
    check("R9 W loaded", w_o, 8'h01);
    do_op(0, 1, 8'h00, 8'h0F, 0, 0);            // 0x0F + 0x01
    check("R2 0F+01 result", out_result, 8'h10);
    check("R2 0F+01 STATUS", status_o, 8'h1A);
    do_op(1, 1, 8'h00, 8'h00, 0, 0);            // 0x00 - 0x01
    check("R3 00-01 result", out_result, 8'hFF);
    check("R3 00-01 STATUS", status_o, 8'h18);
    do_op(1, 1, 8'h00, 8'h01, 0, 0);            // 0x01 - 0x01
    check("R3 01-01 result", out_result, 8'h00);
    check("R3 01-01 STATUS", status_o, 8'h1F);
    do_op(0, 0, 8'hFF, 8'h05, 0, 0);            // R8: file operand 0xFF, literal ignored
    check("R8 file operand result", out_result, 8'h00);
    check("R2 FF+01 STATUS", status_o, 8'h1F);
    do_op(8, 1, 8'h00, 8'h80, 0, 0);            // rotate left, C in = 1
    check("R5 rotate left result", out_result, 8'h01);
    check("R5 rotate left STATUS", status_o, 8'h1F);
    do_op(9, 1, 8'h00, 8'h02, 0, 0);            // rotate right, C in = 1
    check("R5 rotate right result", out_result, 8'h81);
    check("R5 rotate right STATUS", status_o, 8'h1E);
    do_op(10, 1, 8'h00, 8'hA5, 0, 0);
    check("R6 swap result", out_result, 8'h5A);
    check("R6 swap STATUS", status_o, 8'h1E);
    do_op(2, 1, 8'h00, 8'h0F, 0, 0);
    check("R4 and STATUS", status_o, 8'h1A);
    do_op(11, 1, 8'h00, 8'hE3, 0, 1);           // write to STATUS
    check("R10 move to STATUS", status_o, 8'hFB);
    do_op(12, 1, 8'h00, 8'h00, 0, 1);
    check("R10 clear to STATUS", status_o, 8'h1C);
    do_op(4, 1, 8'h00, 8'hFF, 1, 0);
    check("R9 xor into W", w_o, 8'hFE);
    do_op(6, 1, 8'h00, 8'hFF, 0, 0);
    check("R4 increment wrap", out_result, 8'h00);
    check("R7 increment mask", {5'b0, out_flags_upd}, 8'h04);

    // R1 / R12: back-pressure holds the result and blocks new work
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_use_lit = 1'b1; in_lit = 8'h01; in_dst_w = 1'b1; in_dst_status = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_op = 4'd12; in_dst_status = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 held result", out_result, 8'hFF);
    check("R1 blocked ready", {7'b0, in_ready}, 8'h00);
    check("R12 W unchanged while blocked", w_o, 8'hFF);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);

    // mixed traffic with random back-pressure
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      in_valid      = ($urandom % 4) != 0;
      out_ready     = ($urandom % 3) != 0;
      in_op         = 4'($urandom % 16);
      in_use_lit    = 1'($urandom % 2);
      in_file       = 8'($urandom);
      in_lit        = 8'($urandom);
      in_dst_w      = 1'($urandom % 2);
      in_dst_status = ($urandom % 5) == 0;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule